// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable behavioural model of a synchronous static RAM. Read and write commands can follow each other on consecutive clock edges with no idle cycle between them. The data path is split into four 9-bit byte lanes. At the pad, the bus is modelled as an input word, an output word and a driver enable: a low driver enable means the bus is high-impedance.

Write data trails its command by the same number of edges that read data trails a read command. This is why the bus can turn around without a dead cycle. A static mode input selects one of two latencies:

- **Pipelined:** read data is held in an output register, and write data is taken two edges after the command.
- **Flow-through:** both are one edge shorter.

A command can also continue the previous operation. It steps a 2-bit burst counter in the low address bits, and the chip enables and write enable are ignored on that cycle.

The model is meant to sit in front of a controller under test. It stands in for an external memory device, so the controller's bus timing can be checked cycle by cycle.

Top module: `zt_sram`

## Requirements
- R1: In pipelined mode (`flow_mode`=0), read data for a command sampled on enabled edge n is driven from enabled edge n+1 until enabled edge n+2.
- R2: In flow-through mode (`flow_mode`=1), read data for a command sampled on enabled edge n is driven from edge n until edge n+1.
- R3: Write data is sampled from `dq_i` on enabled edge n+2 in pipelined mode and on enabled edge n+1 in flow-through mode, where n is the edge that took the write command.
- R4: With `adv_ld`=0, the part is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. If selected, `we_n`=1 starts a read and `we_n`=0 starts a write at `addr`. Any inactive enable gives a deselect cycle with no bus drive.
- R5: With `adv_ld`=1, the previous operation type repeats, whatever the enables and `we_n` are doing. The address keeps its upper bits and adds one to its two low bits, modulo 4.
- R6: A continue cycle that follows a deselect cycle is itself a deselect cycle.
- R7: `bw_n[i]` (active low) writes `dq_i[9i+8:9i]`. A write with all four bits high modifies no location.
- R8: An edge with `cke_n`=1 changes no state. A driven read keeps driving the same data, and a stalled write slot leaves the bus released.
- R9: `oe_n`=1 releases the bus at once. A read issued while `oe_n`=1 still advances the pipeline and the burst counter.
- R10: `sleep`=1 releases the bus at once and freezes all state on the edges it covers.
- R11: After reset, the bus is released.
- R12: A read always returns the most recent write to that address, including a write whose data is still in the pipeline.
- R13: The driver enable is never asserted in a slot where write data is expected on `dq_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| flow_mode | input | 1 | 1 = flow-through latency, 0 = pipelined latency (static) |
| cke_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write select for new commands, active low |
| bw_n | input | NB (4) | Per-lane write enables, active low |
| adv_ld | input | 1 | 1 = continue burst, 0 = load new address and command |
| addr | input | AW (8) | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq_i | input | NB*LW (36) | Data arriving from the bus |
| dq_o | output | NB*LW (36) | Data the model would drive |
| dq_oe | output | 1 | Bus driver enable; 0 = high-impedance |

## Verification
On every cycle, the assertions check several properties:
- a deselect or continued deselect leaves no live command;
- a continue cycle steps the low address bits and keeps the operation type;
- stalls and sleep freeze the command stages;
- a pipelined read drives the bus exactly one enabled edge later;
- a write slot never drives the bus;
- full-lane forwarding hands the in-flight write data to a following read.

Some behaviours only the bench's scenarios can show:
- the exact latency of each mode, and the data that comes back after lane-masked writes;
- a full address sweep with read and write alternating every edge;
- burst wrap order, and dummy reads that still advance the counter;
- stalls that hold a driven word, and sleep windows in the middle of a read.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int BURST_W = 2;

  // Linear burst order: the low bits count up and wrap inside an aligned group.
  function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] cur);
    return cur + BURST_W'(1);
  endfunction

endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic          adv_ld,
  input  logic          sel,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output logic [NB-1:0] s1_bw,
  output op_e           s2_op,
  output logic [AW-1:0] s2_addr,
  output logic [NB-1:0] s2_bw
);

  op_e           nxt_op;
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] cont_addr;

  assign cont_addr = {s1_addr[AW-1:BURST_W], burst_step(s1_addr[BURST_W-1:0])};

  always_comb begin
    if (adv_ld) begin
      nxt_op   = s1_op;
      nxt_addr = cont_addr;
    end else if (!sel) begin
      nxt_op   = OP_IDLE;
      nxt_addr = s1_addr;
    end else begin
      nxt_op   = we_n ? OP_READ : OP_WRITE;
      nxt_addr = addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op <= OP_IDLE;
      s2_op <= OP_IDLE;
    end else if (adv_en) begin
      s1_op <= nxt_op;
      s2_op <= s1_op;
    end
  end

  always_ff @(posedge clk) begin
    if (adv_en) begin
      s1_addr <= nxt_addr;
      s1_bw   <= bw_n;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
    end
  end

  p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !adv_ld && !sel) |=> (s1_op == OP_IDLE));

  p_new_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !adv_ld && sel) |=> (s1_op == ($past(we_n) ? OP_READ : OP_WRITE)));

  p_cont_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && adv_ld && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE));

  p_burst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && adv_ld && s1_op != OP_IDLE) |=>
      (s1_op == $past(s1_op)) &&
      (s1_addr[BURST_W-1:0] == $past(s1_addr[BURST_W-1:0]) + BURST_W'(1)) &&
      (s1_addr[AW-1:BURST_W] == $past(s1_addr[AW-1:BURST_W])));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(s1_op) && $stable(s2_op) && $stable(s1_addr));

endmodule

// File: rtl/zt_store.sv
module zt_store
  import zt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_en,
  input  logic               flow,
  input  op_e                s1_op,
  input  logic [AW-1:0]      s1_addr,
  input  logic [NB-1:0]      s1_bw,
  input  op_e                s2_op,
  input  logic [AW-1:0]      s2_addr,
  input  logic [NB-1:0]      s2_bw,
  input  logic [NB*LW-1:0]   din,
  output logic [NB*LW-1:0]   rd_data
);

  localparam int W     = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  out_q;
  logic [W-1:0]  core_rd;
  logic [W-1:0]  pipe_next;
  op_e           c_op;
  logic [AW-1:0] c_addr;
  logic [NB-1:0] c_bw;
  logic          commit;
  logic          fwd_hit;

  // Replace each lane whose active-low enable is asserted.
  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w,
                                               input logic [W-1:0] new_w,
                                               input logic [NB-1:0] en_n);
    logic [W-1:0] r;
    r = old_w;
    for (int i = 0; i < NB; i++)
      if (!en_n[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  // Write data lands one stage later in pipelined mode than in flow-through.
  assign c_op   = flow ? s1_op   : s2_op;
  assign c_addr = flow ? s1_addr : s2_addr;
  assign c_bw   = flow ? s1_bw   : s2_bw;
  assign commit = adv_en && (c_op == OP_WRITE);

  assign core_rd   = mem[s1_addr];
  assign fwd_hit   = !flow && (s2_op == OP_WRITE) && (s2_addr == s1_addr);
  assign pipe_next = fwd_hit ? lane_merge(core_rd, din, s2_bw) : core_rd;

  always_ff @(posedge clk) begin
    if (commit) mem[c_addr] <= lane_merge(mem[c_addr], din, c_bw);
  end

  always_ff @(posedge clk) begin
    if (adv_en && !flow) out_q <= pipe_next;
  end

  assign rd_data = flow ? core_rd : out_q;

  p_fwd_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && fwd_hit && s1_op == OP_READ && s2_bw == '0) |=>
      (flow || rd_data == $past(din)));

endmodule

// File: rtl/zt_bus.sv
module zt_bus
  import zt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flow,
  input  logic adv_en,
  input  op_e  s1_op,
  input  op_e  s2_op,
  input  logic oe_n,
  input  logic sleep,
  output logic dq_oe
);

  op_e show_op;

  assign show_op = flow ? s1_op : s2_op;
  assign dq_oe   = (show_op == OP_READ) && !oe_n && !sleep;

  p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && !oe_n && !sleep && $past(adv_en) && $past(s1_op == OP_READ)) |-> dq_oe);

  p_wr_hiz_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && $past(adv_en) && $past(s1_op == OP_WRITE)) |-> !dq_oe);

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_mode,
  input  logic             cke_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic [NB-1:0]    bw_n,
  input  logic             adv_ld,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [NB*LW-1:0] dq_i,
  output logic [NB*LW-1:0] dq_o,
  output logic             dq_oe
);

  logic          adv_en;
  logic          sel;
  op_e           s1_op, s2_op;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NB-1:0] s1_bw, s2_bw;

  assign adv_en = !cke_n && !sleep;
  assign sel    = !ce1_n && ce2 && !ce3_n;

  zt_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .adv_ld(adv_ld), .sel(sel),
    .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_bw(s1_bw),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_bw(s2_bw)
  );

  zt_store #(.AW(AW), .NB(NB), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .flow(flow_mode),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_bw(s1_bw),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_bw(s2_bw),
    .din(dq_i), .rd_data(dq_o)
  );

  zt_bus u_bus (
    .clk(clk), .rst_n(rst_n), .flow(flow_mode), .adv_en(adv_en),
    .s1_op(s1_op), .s2_op(s2_op), .oe_n(oe_n), .sleep(sleep), .dq_oe(dq_oe)
  );

  p_sleep_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(s1_op) && $stable(s2_op) && $stable(s1_addr));

endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flow_mode = 1'b0;
  logic        cke_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic        we_n = 1'b1, adv_ld = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]  bw_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] dq_i = '0;
  logic [35:0] dq_o;
  logic        dq_oe;

  always #10 clk = ~clk;

  zt_sram u0 (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cke_n(cke_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n),
    .adv_ld(adv_ld), .addr(addr), .oe_n(oe_n), .sleep(sleep),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_tag = "R11";

  logic [35:0] ref_mem [256];
  bit          rd_v [64];
  logic [35:0] rd_d [64];
  bit          wr_v [64];
  logic [35:0] wr_d [64];
  int          k = 0;
  int          m_op = 0;        // 0 idle, 1 read, 2 write
  logic [7:0]  m_addr = '0;
  int          wseq = 0;

  function automatic logic [35:0] pat(input int s);
    return {9'(s * 3 + 1), 9'(s * 5 + 2), 9'(s * 7 + 3), 9'(s * 11 + 4)};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic step(input bit a_cke_n, input bit a_sleep, input bit a_oe_n, input bit a_adv,
                      input bit a_ce1_n, input bit a_ce2, input bit a_ce3_n, input bit a_we_n,
                      input logic [3:0] a_bw, input logic [7:0] a_addr);
    int  c, lat;
    bit  drv;
    logic [35:0] wd;
    @(negedge clk);
    cke_n = a_cke_n; sleep = a_sleep; oe_n = a_oe_n; adv_ld = a_adv;
    ce1_n = a_ce1_n; ce2 = a_ce2; ce3_n = a_ce3_n; we_n = a_we_n;
    bw_n = a_bw; addr = a_addr;
    dq_i = wr_v[k % 64] ? wr_d[k % 64] : 36'h5A5A5A5A5;
    #1;
    drv = rd_v[k % 64] && !a_oe_n && !a_sleep;
    chk(dq_oe == drv, "bus enable", {35'b0, dq_oe}, {35'b0, drv});
    if (drv) chk(dq_o == rd_d[k % 64], "read data", dq_o, rd_d[k % 64]);
    if (wr_v[k % 64]) chk(!dq_oe, "R13 write slot left free", {35'b0, dq_oe}, 36'b0);
    @(posedge clk);
    if (!a_cke_n && !a_sleep) begin
      c   = k;
      lat = flow_mode ? 1 : 2;
      if (!a_adv) begin
        if (!a_ce1_n && a_ce2 && !a_ce3_n) begin
          m_op = a_we_n ? 1 : 2;
          m_addr = a_addr;
        end else m_op = 0;
      end else if (m_op != 0) begin
        m_addr = {m_addr[7:2], m_addr[1:0] + 2'd1};
      end
      rd_v[c % 64] = 0;
      wr_v[c % 64] = 0;
      if (m_op == 1) begin
        rd_v[(c + lat) % 64] = 1;
        rd_d[(c + lat) % 64] = ref_mem[m_addr];
      end else if (m_op == 2) begin
        wd = pat(wseq);
        wseq++;
        for (int i = 0; i < 4; i++)
          if (!a_bw[i]) ref_mem[m_addr][i*9 +: 9] = wd[i*9 +: 9];
        wr_v[(c + lat) % 64] = 1;
        wr_d[(c + lat) % 64] = wd;
      end
      k++;
    end
  endtask

  task automatic rd(input logic [7:0] a, input bit o = 0);
    step(0, 0, o, 0, 0, 1, 0, 1, 4'hF, a);
  endtask
  task automatic wr(input logic [7:0] a, input logic [3:0] b);
    step(0, 0, 0, 0, 0, 1, 0, 0, b, a);
  endtask
  task automatic cont(input logic [3:0] b, input bit o = 0);
    step(0, 0, o, 1, 1, 0, 1, 1, b, 8'hEE);   // enables and we_n deliberately inactive
  endtask
  task automatic desel(input int which);
    step(0, 0, 0, 0, which == 0, which != 1, which == 2, 1, 4'h0, 8'h33);
  endtask
  task automatic stall(input bit o = 0);
    step(1, 0, o, 0, 0, 1, 0, 0, 4'h0, 8'h44);
  endtask
  task automatic nap();
    step(0, 1, 0, 0, 0, 1, 0, 0, 4'h0, 8'h55);
  endtask

  task automatic mixed_run(input int n);
    for (int i = 0; i < n; i++) begin
      cur_tag = flow_mode ? "R2" : "R1";
      rd(8'(3 * i));
      cur_tag = "R3";
      wr(8'(3 * i), 4'(i));
      cur_tag = "R12";
      rd(8'(3 * i));
      cur_tag = "R3";
      wr(8'(3 * i + 1), 4'h0);
    end
  endtask

  task automatic special_cases();
    cur_tag = "R7";
    for (int b = 0; b < 16; b++) begin
      wr(8'd100, 4'(b));
      rd(8'd100);
    end
    cur_tag = "R5";
    wr(8'h12, 4'h0); cont(4'h0); cont(4'h3); cont(4'h0);
    rd(8'h12); cont(4'hF); cont(4'hF); cont(4'hF); cont(4'hF);
    cur_tag = "R4";
    rd(8'd5); desel(0); desel(1); desel(2);
    cur_tag = "R6";
    cont(4'h0); cont(4'h0); rd(8'd5); desel(1); cont(4'hF);
    cur_tag = "R8";
    rd(8'd7); stall(); stall(); stall(); wr(8'd8, 4'h0); stall(); stall(); rd(8'd8);
    cont(4'hF); stall(); desel(0); desel(0);
    cur_tag = "R9";
    rd(8'd9, 1); cont(4'hF, 0); cont(4'hF, 1); cont(4'hF, 0); desel(0); desel(0);
    cur_tag = "R10";
    rd(8'd11); nap(); nap(); cont(4'hF); desel(0); desel(0); desel(0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin rd_v[i] = 0; wr_v[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_tag = "R11";
    chk(dq_oe == 1'b0, "released in reset", {35'b0, dq_oe}, 36'b0);
    rst_n = 1'b1;
    #1;
    chk(dq_oe == 1'b0, "released after reset", {35'b0, dq_oe}, 36'b0);

    cur_tag = "R3";
    for (int a = 0; a < 256; a++) wr(8'(a), 4'h0);
    cur_tag = "R1";
    for (int a = 0; a < 256; a += 17) rd(8'(a));
    mixed_run(40);
    special_cases();

    @(negedge clk);
    flow_mode = 1'b1;
    cur_tag = "R2";
    for (int a = 0; a < 256; a += 9) begin rd(8'(a)); wr(8'(a), 4'h0); end
    mixed_run(40);
    special_cases();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule